// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives the timing reference of a serial port from the system clock. It produces a single-cycle oversampling tick whose mean period equals a fixed-point divisor. The divisor has a 16-bit integer part and a 6-bit fractional part in units of 1/64 of a clock. A receiver uses that tick to sample the line. A second single-cycle tick marks every bit period and drives a transmitter. The bit tick fires on every 16th oversampling tick, or on every 8th when the high-speed select is set.

The divisor is computed outside the block as the system clock divided by the product of the oversampling factor and the baud rate. For example, a 20 MHz clock at 115200 baud with 16x oversampling gives an integer part of 10 and a fractional part of 54. The divisor inputs may change at any time. A value takes effect only on the clock edge where the commit strobe is high; until then the previously committed divisor remains in use.

The fraction is spread over time by a 6-bit phase accumulator. Every period the fraction is added to the accumulator. A period in which that addition carries is one clock longer than the integer part.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted both ticks are low. The committed divisor resets to zero, so no tick appears after reset until a divisor is committed.
- R2: With a committed divisor I + F/64 (I ≥ 1), any 64 consecutive oversampling intervals sum to exactly 64·I + F clocks.
- R3: Every oversampling interval is either I or I+1 clocks long.
- R4: With F = 0 every interval is exactly I clocks. With I = 1 and F = 0 the oversampling tick is high on every clock.
- R5: With the high-speed select low, the bit tick is high only in cycles where the oversampling tick is high, and it fires once per 16 oversampling ticks.
- R6: With the high-speed select high, the bit tick fires once per 8 oversampling ticks.
- R7: Changes on the divisor inputs have no effect until the commit strobe is high at a clock edge. On that edge both parts are loaded together.
- R8: While enable is low no tick is produced. The interval counter, the phase accumulator and the bit counter restart from zero. After enable rises, the first oversampling tick appears exactly I clocks later, and the first bit tick coincides with the 16th oversampling tick (16x mode).
- R9: A committed integer part of zero suppresses all ticks.
- R10: When I ≥ 2, the oversampling tick is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds all counters at zero |
| div_int | input | 16 | Integer part of the pending divisor |
| div_frac | input | 6 | Fractional part of the pending divisor, units of 1/64 |
| fast_mode | input | 1 | 0: 16x oversampling, 1: 8x oversampling |
| commit | input | 1 | Loads the pending divisor into the active one |
| os_tick | output | 1 | Oversampling tick, one cycle wide |
| bit_tick | output | 1 | Bit-period tick, coincides with an oversampling tick |

## Verification
The bench measures the intervals between oversampling ticks over a full accumulator cycle, using the 10 + 54/64 case and an almost-doubled 1 + 63/64 case. A design that drops or double-counts the carry would miss the exact sum of 694 or 127 clocks, or produce intervals outside I and I+1. It then moves the divisor inputs without a commit and expects the old period to persist, which catches a design that reads the inputs directly. It disables the block in the middle of a period and checks that the first tick comes exactly I clocks after re-enabling and that the first bit tick lands on the 16th oversampling tick. Counters that were only paused, instead of cleared, would shift both. Bit spacing is checked in both oversampling modes, and committing a zero integer part must silence both outputs rather than wrap the counter.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_INT_W  = 16;
    localparam int DIV_FRAC_W = 6;
    localparam int OS_SLOW    = 16;
    localparam int OS_FAST    = 8;
endpackage

// File: rtl/baud_div_shadow.sv
module baud_div_shadow #(
    parameter int INT_W  = baud_pkg::DIV_INT_W,
    parameter int FRAC_W = baud_pkg::DIV_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac
);
    typedef struct packed {
        logic [INT_W-1:0]  ip;
        logic [FRAC_W-1:0] fp;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.ip = div_int;
            st_d.fp = div_frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_int  = st_q.ip;
    assign act_frac = st_q.fp;
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
    parameter int INT_W  = baud_pkg::DIV_INT_W,
    parameter int FRAC_W = baud_pkg::DIV_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INT_W-1:0]  act_int,
    input  logic [FRAC_W-1:0] act_frac,
    output logic              tick_next,
    output logic              os_tick
);
    localparam int LAST_W = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } st_t;

    st_t st_d, st_q;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic [LAST_W-1:0] last;
    logic              valid;
    logic              wrap;

    always_comb begin
        acc_sum = {1'b0, st_q.acc} + {1'b0, act_frac};
        carry   = acc_sum[FRAC_W];
        last    = {1'b0, act_int} + {{INT_W{1'b0}}, carry} - LAST_W'(1);
        valid   = (act_int != '0);
        wrap    = ({1'b0, st_q.cnt} >= last);

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (valid) begin
            if (wrap) begin
                st_d.cnt  = '0;
                st_d.acc  = acc_sum[FRAC_W-1:0];
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + INT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_next = st_d.tick;
    assign os_tick   = st_q.tick;
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
    parameter int SLOW = baud_pkg::OS_SLOW,
    parameter int FAST = baud_pkg::OS_FAST
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fast_mode,
    input  logic tick_in,
    output logic bit_tick
);
    localparam int CW = $clog2(SLOW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        last      = fast_mode ? CW'(FAST - 1) : CW'(SLOW - 1);
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (tick_in) begin
            if (st_q.cnt >= last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_tick = st_q.tick;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int INT_W  = baud_pkg::DIV_INT_W,
    parameter int FRAC_W = baud_pkg::DIV_FRAC_W,
    parameter int SLOW   = baud_pkg::OS_SLOW,
    parameter int FAST   = baud_pkg::OS_FAST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              fast_mode,
    input  logic              commit,
    output logic              os_tick,
    output logic              bit_tick
);
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              tick_next;

    baud_div_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .div_int(div_int), .div_frac(div_frac),
        .act_int(act_int), .act_frac(act_frac)
    );

    baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .act_int(act_int), .act_frac(act_frac),
        .tick_next(tick_next), .os_tick(os_tick)
    );

    baud_bit_div #(.SLOW(SLOW), .FAST(FAST)) u_bit (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .tick_in(tick_next), .bit_tick(bit_tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              commit,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic [INT_W-1:0]  act_int,
    input logic [FRAC_W-1:0] act_frac,
    input logic              os_tick,
    input logic              bit_tick
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!os_tick && !bit_tick);
        end
    end

    p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_int) && $stable(act_frac)));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_int == $past(div_int) && act_frac == $past(div_frac)));

    p_gate_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!os_tick && !bit_tick));

    p_zero_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_int == '0) |=> !os_tick);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && act_int > INT_W'(1)) |=> !os_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .commit(commit),
    .div_int(div_int), .div_frac(div_frac),
    .act_int(act_int), .act_frac(act_frac),
    .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_int = '0;
    logic [5:0]  div_frac = '0;
    logic        fast_mode = 1'b0;
    logic        commit = 1'b0;
    logic        os_tick, bit_tick;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_int(div_int),
        .div_frac(div_frac), .fast_mode(fast_mode), .commit(commit),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_div(input int ip, input int fp);
        @(negedge clk);
        div_int  = 16'(ip);
        div_frac = 6'(fp);
        commit   = 1'b1;
        @(negedge clk);
        commit   = 1'b0;
    endtask

    // Sum, min and max of n intervals between consecutive oversampling ticks
    task automatic measure(input int n, output int sum, output int mn, output int mx);
        int gap = 0;
        int got = 0;
        bit started = 0;
        int guard = 0;
        sum = 0; mn = 1000000; mx = 0;
        while (got < n && guard < 40000) begin
            @(negedge clk);
            guard++;
            if (started) gap++;
            if (os_tick) begin
                if (started) begin
                    sum += gap;
                    if (gap < mn) mn = gap;
                    if (gap > mx) mx = gap;
                    got++;
                end
                started = 1;
                gap = 0;
            end
        end
    endtask

    task automatic count_ticks(input int ncyc, output int nos, output int nbit);
        nos = 0; nbit = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (os_tick) nos++;
            if (bit_tick) nbit++;
        end
    endtask

    // Oversampling ticks from one bit tick to the next, inclusive of the second
    task automatic bit_spacing(output int n);
        int guard = 0;
        n = 0;
        while (!bit_tick && guard < 20000) begin @(negedge clk); guard++; end
        @(negedge clk);
        while (guard < 20000) begin
            guard++;
            if (os_tick) n++;
            if (bit_tick) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int nos, nbit;
        @(negedge clk);
        check("R1 os_tick in reset", int'(os_tick), 0);
        check("R1 bit_tick in reset", int'(bit_tick), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        count_ticks(100, nos, nbit);
        check("R1 no ticks before commit", nos + nbit, 0);
    endtask

    task automatic t_example;
        int s, mn, mx;
        load_div(10, 54);
        measure(64, s, mn, mx);
        check("R2 sum of 64 intervals 10+54/64", s, 694);
        check("R3 min interval", mn, 10);
        check("R3 max interval", mx, 11);
        load_div(1, 63);
        measure(64, s, mn, mx);
        check("R2 sum of 64 intervals 1+63/64", s, 127);
        check("R3 max interval 1+63/64", mx, 2);
    endtask

    task automatic t_integer;
        int s, mn, mx, nos, nbit;
        load_div(3, 0);
        measure(20, s, mn, mx);
        check("R4 min interval I=3", mn, 3);
        check("R4 max interval I=3", mx, 3);
        load_div(1, 0);
        repeat (3) @(negedge clk);
        count_ticks(50, nos, nbit);
        check("R4 tick every cycle I=1", nos, 50);
    endtask

    task automatic t_bits;
        int n;
        load_div(2, 0);
        fast_mode = 1'b0;
        bit_spacing(n);
        bit_spacing(n);
        check("R5 os ticks per bit tick 16x", n, 16);
        fast_mode = 1'b1;
        bit_spacing(n);
        bit_spacing(n);
        check("R6 os ticks per bit tick 8x", n, 8);
        fast_mode = 1'b0;
        bit_spacing(n);
        bit_spacing(n);
        check("R5 back to 16x", n, 16);
    endtask

    task automatic t_commit;
        int s, mn, mx;
        load_div(5, 0);
        measure(4, s, mn, mx);
        @(negedge clk);
        div_int  = 16'd9;
        div_frac = 6'd32;
        measure(10, s, mn, mx);
        check("R7 uncommitted min", mn, 5);
        check("R7 uncommitted max", mx, 5);
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        measure(64, s, mn, mx);
        check("R7 committed sum", s, 64 * 9 + 32);
    endtask

    task automatic t_enable;
        int nos, nbit, lat, cnt_os;
        load_div(10, 54);
        fast_mode = 1'b0;
        repeat (37) @(negedge clk);
        enable = 1'b0;
        count_ticks(60, nos, nbit);
        check("R8 no ticks while disabled", nos + nbit, 0);
        enable = 1'b1;
        lat = 0;
        cnt_os = 0;
        while (lat < 100) begin
            @(negedge clk);
            lat++;
            if (os_tick) break;
        end
        check("R8 first tick latency", lat, 10);
        cnt_os = 1;
        while (!bit_tick && cnt_os < 100) begin
            @(negedge clk);
            if (os_tick) cnt_os++;
        end
        check("R8 first bit tick on 16th os tick", cnt_os, 16);
    endtask

    task automatic t_zero;
        int nos, nbit;
        load_div(4, 0);
        repeat (20) @(negedge clk);
        load_div(0, 40);
        count_ticks(200, nos, nbit);
        check("R9 zero integer suppresses ticks", nos + nbit, 0);
    endtask

    task automatic t_pulse;
        int s, mn, mx;
        load_div(2, 0);
        measure(20, s, mn, mx);
        check("R10 pulse spacing I=2", mn, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        t_example;
        t_integer;
        t_bits;
        t_commit;
        t_enable;
        t_zero;
        t_pulse;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule